// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block guards one slave port of an on-chip interconnect. Each bus request presents an address, the number of the master issuing it, an access kind (read, write or instruction fetch), a privilege level and a process tag. The checker matches the address against a small table of region descriptors and answers one cycle later with a grant or a denial. A denial carries a cause code that separates three cases: no region matched, exactly one region matched, or several overlapping regions matched and none of them permitted the access.

Each descriptor holds a lower bound, an upper bound, a 32-bit rights word, a process tag, a tag mask and a valid flag. The bounds work on 32-byte granules. Masters 0 to 3 have encoded privileged and unprivileged read/write/execute rights and can require a process-tag match. Masters 4 to 7 have only a read enable and a write enable. A global enable switches all checking on or off. The descriptors are loaded through a write-only configuration port, and that port tags each write with the writing master. Region 0 is guarded against master 0, the main processor: it cannot change the region's bounds or the rights of master 1, the debug port.

The region count is a parameter. It is meant to be 8, 12 or 16. The master count is a parameter of at most 8.

Top module: `mpu_access_checker`

## Requirements
- R1: A region's lower bound keeps only address bits [31:5] of the written value, with bits [4:0] read as zero. Its upper bound keeps bits [31:5], with bits [4:0] read as one. An address matches when it lies between the two bounds, both ends included.
- R2: For masters 0 to 3, the master's 6-bit rights field sits at bit 6*m of the rights word. In that field, bits [2:0] are the unprivileged code: bit 2 = read, bit 1 = write, bit 0 = execute (for example 4 = R, 6 = RW, 7 = RWX). An unprivileged request is allowed only when its kind's bit is set.
- R3: In a privileged request from masters 0 to 3, field bits [4:3] select the rights: 0 gives RWX, 1 gives RX, 2 gives RW, 3 uses the unprivileged code.
- R4: For masters 4 to 7, a 2-bit field at bit 24 + 2*(m-4) holds write enable in its bit 0 and read enable in its bit 1. Privilege does not matter for these masters, and an execute request is checked as a read.
- R5: A write from master 0 to region 0 leaves the region's bounds unchanged and leaves rights bits [11:6] (master 1's field) unchanged. It does update all other rights bits. Writes from any other master change everything.
- R6: When bit 5 of a master's field (masters 0 to 3) is set, the region matches only if the region tag equals the request tag on every bit that is clear in the region's tag mask. Otherwise the region counts as not matched.
- R7: A region whose valid flag (control word bit 0) is clear never matches.
- R8: While the global enable is clear, every request is granted.
- R9: A denial reports cause 0 when no region matched, 1 when exactly one matched and 2 when two or more matched. Cause 3 never occurs, and a grant reports cause 0.
- R10: When several regions match, the request is granted if any one of them allows it.
- R11: Every request cycle produces exactly one response, in the next cycle. No response is given without a request, and no response is pending after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_master | input | 3 | Master issuing the configuration write |
| cfg_region | input | $clog2(NUM_REGIONS) | Descriptor index |
| cfg_sel | input | 3 | Word select: 0 lower bound, 1 upper bound, 2 rights, 3 control ({mask[23:16], tag[15:8], valid[0]}), 4 global enable (bit 0) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_master | input | 3 | Requesting master |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_priv | input | 1 | 1 = privileged (supervisor) |
| req_pid | input | 8 | Request process tag |
| resp_valid | output | 1 | Response present |
| resp_grant | output | 1 | 1 = access allowed |
| resp_code | output | 2 | Denial cause |

## Verification
The main check is driven with addresses just inside and just outside each region's granule edges, which separates correct bound rounding from off-by-one comparisons. Requests from every rights class are then tried in both privilege levels and with all three access kinds. This separates the unprivileged code, the privileged codes and the read-only handling of execute for the upper masters. Requests inside one region, inside two overlapping regions and outside all regions show whether the "any region allows" rule and the three denial causes are kept apart. Process tags are used that differ only in masked bits and in unmasked bits. Last, writes to region 0 by the processor and by another master show the lock and the fields it must leave writable.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

  localparam int ADDR_W      = 32;
  localparam int GRAN_W      = 5;
  localparam int PID_W       = 8;
  localparam int RIGHTS_W    = 32;
  localparam int LOW_FIELD_W = 6;
  localparam int HIGH_BASE   = 24;
  localparam int BOUND_W     = ADDR_W - GRAN_W;
  localparam int MASTER_W    = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    DENY_NO_HIT  = 2'd0,
    DENY_SINGLE  = 2'd1,
    DENY_OVERLAP = 2'd2
  } deny_code_e;

  typedef enum logic [2:0] {
    SEL_START  = 3'd0,
    SEL_END    = 3'd1,
    SEL_RIGHTS = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_GLOBAL = 3'd4
  } cfg_sel_e;

  typedef struct packed {
    logic [BOUND_W-1:0]  lo;
    logic [BOUND_W-1:0]  hi;
    logic [RIGHTS_W-1:0] rights;
    logic [PID_W-1:0]    pid;
    logic [PID_W-1:0]    pid_mask;
    logic                valid;
  } region_t;

  // Effective RWX bits ({R,W,X}) of a lower-class master field.
  function automatic logic [2:0] low_eff_rwx(input logic [LOW_FIELD_W-1:0] f,
                                             input logic priv);
    logic [2:0] e;
    e = f[2:0];
    if (priv) begin
      case (f[4:3])
        2'd0:    e = 3'b111;
        2'd1:    e = 3'b101;
        2'd2:    e = 3'b110;
        default: e = f[2:0];
      endcase
    end
    return e;
  endfunction

  // Permission of one rights word for a master, access kind and mode.
  function automatic logic perm_ok(input logic [RIGHTS_W-1:0] rights,
                                   input logic [MASTER_W-1:0] master,
                                   input logic [1:0]          kind,
                                   input logic                priv);
    logic [LOW_FIELD_W-1:0] f;
    logic [1:0]             rw;
    logic [2:0]             e;
    logic                   ok;
    f  = rights[int'(master[1:0])*LOW_FIELD_W +: LOW_FIELD_W];
    rw = rights[HIGH_BASE + int'(master[1:0])*2 +: 2];
    e  = low_eff_rwx(f, priv);
    ok = 1'b0;
    if (!master[2]) begin
      case (kind)
        ACC_READ:  ok = e[2];
        ACC_WRITE: ok = e[1];
        ACC_EXEC:  ok = e[0];
        default:   ok = 1'b0;
      endcase
    end else begin
      case (kind)
        ACC_READ:  ok = rw[1];
        ACC_EXEC:  ok = rw[1];
        ACC_WRITE: ok = rw[0];
        default:   ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/mpu_desc_file.sv
module mpu_desc_file
  import mpu_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [MASTER_W-1:0] cfg_master,
  input  logic [IDX_W-1:0]    cfg_region,
  input  logic [2:0]          cfg_sel,
  input  logic [RIGHTS_W-1:0] cfg_wdata,
  output region_t             desc [NUM_REGIONS],
  output logic                glob_en
);

  localparam logic [RIGHTS_W-1:0] DBG_MASK =
    RIGHTS_W'({LOW_FIELD_W{1'b1}}) << LOW_FIELD_W;

  logic core_writer;
  assign core_writer = (cfg_master == '0);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    logic    wr_en;
    logic    locked;
    region_t cur_q;
    region_t nxt;

    assign wr_en  = cfg_we && (int'(cfg_region) == r) && (cfg_sel != SEL_GLOBAL);
    assign locked = (r == 0) && core_writer;

    always_comb begin
      nxt = cur_q;
      case (cfg_sel)
        SEL_START: if (!locked) nxt.lo = cfg_wdata[ADDR_W-1:GRAN_W];
        SEL_END:   if (!locked) nxt.hi = cfg_wdata[ADDR_W-1:GRAN_W];
        SEL_RIGHTS: begin
          if (locked) nxt.rights = (cfg_wdata & ~DBG_MASK) | (cur_q.rights & DBG_MASK);
          else        nxt.rights = cfg_wdata;
        end
        SEL_CTRL: begin
          nxt.valid    = cfg_wdata[0];
          nxt.pid      = cfg_wdata[8 +: PID_W];
          nxt.pid_mask = cfg_wdata[16 +: PID_W];
        end
        default: nxt = cur_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cur_q <= '0;
      else if (wr_en) cur_q <= nxt;
    end

    assign desc[r] = cur_q;
  end

  logic glob_we;
  logic glob_nxt;
  logic glob_q;

  assign glob_we  = cfg_we && (cfg_sel == SEL_GLOBAL);
  assign glob_nxt = cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       glob_q <= 1'b0;
    else if (glob_we) glob_q <= glob_nxt;
  end

  assign glob_en = glob_q;

  // R5: processor writes cannot move region 0's bounds
  p_bounds_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_region == '0 && core_writer &&
     (cfg_sel == SEL_START || cfg_sel == SEL_END))
    |=> ($stable(desc[0].lo) && $stable(desc[0].hi)));

  // R5: debug master's field in region 0 survives processor writes
  p_dbg_field_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_region == '0 && core_writer && cfg_sel == SEL_RIGHTS)
    |=> $stable(desc[0].rights[2*LOW_FIELD_W-1:LOW_FIELD_W]));

  // R5: the processor's own field of region 0 is still writable
  p_core_field_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_region == '0 && core_writer && cfg_sel == SEL_RIGHTS)
    |=> (desc[0].rights[LOW_FIELD_W-1:0] == $past(cfg_wdata[LOW_FIELD_W-1:0])));

endmodule

// File: rtl/mpu_region_eval.sv
module mpu_region_eval
  import mpu_chk_pkg::*;
#(
  parameter int NUM_MASTERS = 8
) (
  input  region_t             desc,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [MASTER_W-1:0] master,
  input  logic [1:0]          kind,
  input  logic                priv,
  input  logic [PID_W-1:0]    pid,
  output logic                hit,
  output logic                allow
);

  logic in_range;
  logic tag_check;
  logic tag_ok;
  logic master_ok;

  assign in_range  = (addr[ADDR_W-1:GRAN_W] >= desc.lo) &&
                     (addr[ADDR_W-1:GRAN_W] <= desc.hi);
  assign tag_check = !master[2] &&
                     desc.rights[int'(master[1:0])*LOW_FIELD_W + LOW_FIELD_W - 1];
  assign tag_ok    = !tag_check || (((desc.pid ^ pid) & ~desc.pid_mask) == '0);
  assign master_ok = int'(master) < NUM_MASTERS;

  assign hit   = desc.valid && in_range && tag_ok;
  assign allow = hit && master_ok && perm_ok(desc.rights, master, kind, priv);

endmodule

// File: rtl/mpu_resolve.sv
module mpu_resolve
  import mpu_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   glob_en,
  input  logic [NUM_REGIONS-1:0] hit_vec,
  input  logic [NUM_REGIONS-1:0] allow_vec,
  output logic                   resp_valid,
  output logic                   resp_grant,
  output logic [1:0]             resp_code
);

  logic       any_hit;
  logic       multi_hit;
  logic       any_allow;
  logic       grant_d;
  deny_code_e code_d;

  logic       valid_q;
  logic       grant_q;
  deny_code_e code_q;

  always_comb begin
    any_hit   = |hit_vec;
    multi_hit = |(hit_vec & (hit_vec - NUM_REGIONS'(1)));
    any_allow = |allow_vec;
    grant_d   = !glob_en || any_allow;
    if (grant_d || !any_hit) code_d = DENY_NO_HIT;
    else if (multi_hit)      code_d = DENY_OVERLAP;
    else                     code_d = DENY_SINGLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      grant_q <= 1'b0;
      code_q  <= DENY_NO_HIT;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        grant_q <= grant_d;
        code_q  <= code_d;
      end
    end
  end

  assign resp_valid = valid_q;
  assign resp_grant = grant_q;
  assign resp_code  = code_q;

  p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  p_idle_no_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  p_off_grants_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !glob_en) |=> resp_grant);

  p_any_allow_grants_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|allow_vec)) |=> resp_grant);

  p_no_hit_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && glob_en && !(|hit_vec)) |=> (!resp_grant && resp_code == 2'd0));

  p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_code != 2'd3 && (!resp_grant || resp_code == 2'd0)));

  // R7: a permitting region is always a matching one
  p_allow_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((allow_vec & ~hit_vec) == '0));

endmodule

// File: rtl/mpu_access_checker.sv
module mpu_access_checker
  import mpu_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_MASTERS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [2:0]                     cfg_master,
  input  logic [$clog2(NUM_REGIONS)-1:0] cfg_region,
  input  logic [2:0]                     cfg_sel,
  input  logic [31:0]                    cfg_wdata,
  input  logic                           req_valid,
  input  logic [31:0]                    req_addr,
  input  logic [2:0]                     req_master,
  input  logic [1:0]                     req_kind,
  input  logic                           req_priv,
  input  logic [7:0]                     req_pid,
  output logic                           resp_valid,
  output logic                           resp_grant,
  output logic [1:0]                     resp_code
);

  localparam int IDX_W = $clog2(NUM_REGIONS);

  region_t                desc [NUM_REGIONS];
  logic                   glob_en;
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [NUM_REGIONS-1:0] allow_vec;

  mpu_desc_file #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
  ) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_master (cfg_master),
    .cfg_region (cfg_region),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .desc       (desc),
    .glob_en    (glob_en)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_eval
    mpu_region_eval #(
      .NUM_MASTERS (NUM_MASTERS)
    ) u_eval (
      .desc   (desc[r]),
      .addr   (req_addr),
      .master (req_master),
      .kind   (req_kind),
      .priv   (req_priv),
      .pid    (req_pid),
      .hit    (hit_vec[r]),
      .allow  (allow_vec[r])
    );
  end

  mpu_resolve #(
    .NUM_REGIONS (NUM_REGIONS)
  ) u_resolve (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .glob_en    (glob_en),
    .hit_vec    (hit_vec),
    .allow_vec  (allow_vec),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .resp_code  (resp_code)
  );

endmodule

// File: tb/sim_mpu_access_checker.sv
module sim_mpu_access_checker;
  import mpu_chk_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_master;
  logic [2:0]  cfg_region;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [2:0]  req_master;
  logic [1:0]  req_kind;
  logic        req_priv;
  logic [7:0]  req_pid;
  logic        resp_valid;
  logic        resp_grant;
  logic [1:0]  resp_code;

  int checks = 0;
  int fails  = 0;

  bit         exp_g [$];
  logic [1:0] exp_c [$];
  string      exp_t [$];
  bit         mon_g;
  logic [1:0] mon_c;
  string      mon_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_access_checker #(.NUM_REGIONS(8), .NUM_MASTERS(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_master(cfg_master), .cfg_region(cfg_region),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_master(req_master),
    .req_kind(req_kind), .req_priv(req_priv), .req_pid(req_pid),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_code(resp_code)
  );

  // Monitor: pops the scoreboard on every response.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && resp_valid === 1'b1) begin
      checks++;
      if (exp_g.size() == 0) begin
        fails++;
        $display("FAIL R11: response without request grant=%0b expected none", resp_grant);
      end else begin
        mon_g = exp_g.pop_front();
        mon_c = exp_c.pop_front();
        mon_t = exp_t.pop_front();
        if (resp_grant !== mon_g || resp_code !== (mon_g ? 2'd0 : mon_c)) begin
          fails++;
          $display("FAIL %s: grant=%0b code=%0d expected grant=%0b code=%0d",
                   mon_t, resp_grant, resp_code, mon_g, mon_g ? 2'd0 : mon_c);
        end
      end
    end
  end

  task automatic cfg_write(input logic [2:0] m, input logic [2:0] r,
                           input cfg_sel_e s, input logic [31:0] d);
    @(negedge clk);
    req_valid  = 1'b0;
    cfg_we     = 1'b1;
    cfg_master = m;
    cfg_region = r;
    cfg_sel    = s;
    cfg_wdata  = d;
  endtask

  task automatic region_setup(input logic [2:0] r, input logic [31:0] lo,
                              input logic [31:0] hi, input logic [31:0] rights,
                              input logic [31:0] ctrl);
    cfg_write(3'd2, r, SEL_START,  lo);
    cfg_write(3'd2, r, SEL_END,    hi);
    cfg_write(3'd2, r, SEL_RIGHTS, rights);
    cfg_write(3'd2, r, SEL_CTRL,   ctrl);
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] m,
                        input acc_kind_e k, input logic p, input logic [7:0] pid,
                        input bit g, input logic [1:0] c, input string tag);
    @(negedge clk);
    cfg_we     = 1'b0;
    req_valid  = 1'b1;
    req_addr   = a;
    req_master = m;
    req_kind   = k;
    req_priv   = p;
    req_pid    = pid;
    exp_g.push_back(g);
    exp_c.push_back(c);
    exp_t.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we    = 1'b0;
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_master = '0; cfg_region = '0;
    cfg_sel = '0; cfg_wdata = '0; req_valid = 1'b0; req_addr = '0;
    req_master = '0; req_kind = '0; req_priv = 1'b0; req_pid = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || resp_grant !== 1'b0) begin
      fails++;
      $display("FAIL R11: reset valid=%0b grant=%0b expected valid=0 grant=0",
               resp_valid, resp_grant);
    end
    rst_n = 1'b1;

    // R8: region with no rights, global enable still clear
    region_setup(3'd2, 32'h1000, 32'h1FFF, 32'h0, 32'h1);
    access(32'h1000, 3'd2, ACC_WRITE, 1'b0, 8'h0, 1'b1, 2'd0, "R8");
    cfg_write(3'd2, 3'd2, SEL_CTRL, 32'h0);
    cfg_write(3'd2, 3'd0, SEL_GLOBAL, 32'h1);
    // R7: the now-invalid region gives no hit
    access(32'h1000, 3'd2, ACC_WRITE, 1'b0, 8'h0, 1'b0, 2'd0, "R7");

    // Region 1: granule rounding, mixed rights
    region_setup(3'd1, 32'h1003, 32'h1FE0, 32'h0601_E00C, 32'h1);
    access(32'h0FFF, 3'd4, ACC_READ, 1'b0, 8'h0, 1'b0, 2'd0, "R1");
    access(32'h1000, 3'd4, ACC_READ, 1'b0, 8'h0, 1'b1, 2'd0, "R1");
    access(32'h1FFF, 3'd4, ACC_READ, 1'b0, 8'h0, 1'b1, 2'd0, "R1");
    access(32'h2000, 3'd4, ACC_READ, 1'b0, 8'h0, 1'b0, 2'd0, "R1");
    access(32'h1500, 3'd0, ACC_READ,  1'b0, 8'h0, 1'b1, 2'd0, "R2");
    access(32'h1500, 3'd0, ACC_WRITE, 1'b0, 8'h0, 1'b0, 2'd1, "R2");
    access(32'h1500, 3'd0, ACC_EXEC,  1'b0, 8'h0, 1'b0, 2'd1, "R2");
    access(32'h1500, 3'd0, ACC_EXEC,  1'b1, 8'h0, 1'b1, 2'd0, "R3");
    access(32'h1500, 3'd0, ACC_WRITE, 1'b1, 8'h0, 1'b0, 2'd1, "R3");
    access(32'h1500, 3'd2, ACC_WRITE, 1'b1, 8'h0, 1'b1, 2'd0, "R3");
    access(32'h1500, 3'd2, ACC_EXEC,  1'b1, 8'h0, 1'b0, 2'd1, "R3");
    access(32'h1500, 3'd4, ACC_WRITE, 1'b1, 8'h0, 1'b0, 2'd1, "R4");
    access(32'h1500, 3'd4, ACC_EXEC,  1'b0, 8'h0, 1'b1, 2'd0, "R4");
    access(32'h1500, 3'd5, ACC_WRITE, 1'b0, 8'h0, 1'b1, 2'd0, "R4");
    access(32'h1500, 3'd5, ACC_READ,  1'b1, 8'h0, 1'b0, 2'd1, "R4");
    cfg_write(3'd2, 3'd1, SEL_CTRL, 32'h0);
    access(32'h1500, 3'd4, ACC_READ, 1'b0, 8'h0, 1'b0, 2'd0, "R7");
    cfg_write(3'd2, 3'd1, SEL_CTRL, 32'h1);

    // Region 3 overlaps region 1 on 0x1800..0x1FFF
    region_setup(3'd3, 32'h1800, 32'h27FF, 32'h0100_0018, 32'h1);
    access(32'h1900, 3'd4, ACC_WRITE, 1'b0, 8'h0, 1'b1, 2'd0, "R10");
    access(32'h1900, 3'd4, ACC_READ,  1'b0, 8'h0, 1'b1, 2'd0, "R10");
    access(32'h1900, 3'd5, ACC_READ,  1'b0, 8'h0, 1'b0, 2'd2, "R9");
    access(32'h2100, 3'd5, ACC_READ,  1'b0, 8'h0, 1'b0, 2'd1, "R9");
    access(32'h3000, 3'd6, ACC_READ,  1'b0, 8'h0, 1'b0, 2'd0, "R9");

    // Region 4: process tag 0x5A, low nibble masked, master 3 checks tags
    region_setup(3'd4, 32'h8000, 32'h80FF, 32'h00FC_0000, 32'h000F_5A01);
    access(32'h8010, 3'd3, ACC_WRITE, 1'b0, 8'h53, 1'b1, 2'd0, "R6");
    access(32'h8010, 3'd3, ACC_WRITE, 1'b0, 8'h6A, 1'b0, 2'd0, "R6");
    access(32'h8010, 3'd0, ACC_READ,  1'b0, 8'hFF, 1'b0, 2'd1, "R6");

    // Region 0 lock against the processor
    region_setup(3'd0, 32'h4000, 32'h40FF, 32'h3000_07C0, 32'h1);
    access(32'h4000, 3'd6, ACC_READ, 1'b0, 8'h0, 1'b1, 2'd0, "R5");
    cfg_write(3'd0, 3'd0, SEL_START,  32'h0000_0000);
    cfg_write(3'd0, 3'd0, SEL_END,    32'hFFFF_FFFF);
    cfg_write(3'd0, 3'd0, SEL_RIGHTS, 32'h0000_0000);
    access(32'h4000, 3'd1, ACC_READ, 1'b0, 8'h0, 1'b1, 2'd0, "R5");
    access(32'h4000, 3'd6, ACC_READ, 1'b0, 8'h0, 1'b0, 2'd1, "R5");
    access(32'h5000, 3'd1, ACC_READ, 1'b0, 8'h0, 1'b0, 2'd0, "R5");
    cfg_write(3'd0, 3'd1, SEL_START, 32'h6000);
    cfg_write(3'd0, 3'd1, SEL_END,   32'h60FF);
    access(32'h6000, 3'd4, ACC_READ, 1'b0, 8'h0, 1'b1, 2'd0, "R5");

    // R8: global enable cleared again
    cfg_write(3'd2, 3'd0, SEL_GLOBAL, 32'h0);
    access(32'h9000, 3'd6, ACC_WRITE, 1'b0, 8'h0, 1'b1, 2'd0, "R8");

    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (exp_g.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d responses missing expected 0", exp_g.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule